// File: doc/BRIEF.md
# Supply-Monitoring Card Reset Generator

This block watches four supply-good flags (host 5 V, host 3.3 V, card 5 V and card 3.3 V) and drives the reset of an add-in card's back-end logic. A select input chooses between a 3.3 V-only card and a 5 V or mixed card. The reset is asserted whenever a monitored supply is below its trip level. It is held for a fixed power-up timeout after all monitored supplies become good. A card-voltage-good flag and an active-low signals-valid flag tell the host and the bus interface when the card can be used.

An active-low host reset input can also start a reset cycle. The host reset is synchronized and filtered so that short low pulses are ignored. An accepted host reset keeps the card in reset for the power-up timeout or for as long as the host holds it low, whichever is longer. A separate host-supply-good output feeds the power switching logic. It depends only on the host supplies and the select input, so a host reset never disturbs power switching. The comparators and the open-drain output stages lie outside this block.

Top module: `supply_reset_gen`

## Requirements
- R1: While `rst_n` is low, `card_rst_n` is 0, `card_rst` is 1, `card_v_good` is 0 and `sig_valid_n` is 1.
- R2: If any monitored supply flag is 0, `card_rst_n` is 0 and `card_v_good` is 0 from the second rising clock edge on.
- R3: With `vsel`=1 only `host3_ok` and `card3_ok` are monitored. With `vsel`=0 all four flags are monitored.
- R4: Once all monitored flags are 1, `card_v_good` rises after one clock. The reset is released exactly TIMEOUT_CYC+1 clocks after the flags become good, unless a host reset is active.
- R5: A host reset held low for at least GLITCH_CYC clocks after synchronization starts a reset cycle. That cycle lasts TIMEOUT_CYC+1 clocks from acceptance, or until a few clocks after `host_rst_n` returns high, whichever is later.
- R6: A host reset low pulse shorter than GLITCH_CYC clocks has no effect on any output.
- R7: `sig_valid_n` goes low only one clock after `card_rst_n` has gone high. It is high in every cycle in which `card_rst_n` is low.
- R8: `host_sup_ok` is 1 exactly when the monitored host supplies are good (`host3_ok` alone when `vsel`=1, both host flags when `vsel`=0). A host reset does not change it, and does not change `card_v_good`.
- R9: `card_rst` is always the complement of `card_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low logic reset |
| host5_ok | input | 1 | Host 5 V above trip |
| host3_ok | input | 1 | Host 3.3 V above trip |
| card5_ok | input | 1 | Card 5 V above trip |
| card3_ok | input | 1 | Card 3.3 V above trip |
| vsel | input | 1 | 1 = 3.3 V only card, 0 = 5 V or mixed |
| host_rst_n | input | 1 | Asynchronous active-low host reset |
| card_rst_n | output | 1 | Active-low card reset |
| card_rst | output | 1 | Active-high card reset |
| card_v_good | output | 1 | Monitored supplies all good (low = fault) |
| sig_valid_n | output | 1 | Active-low signals valid |
| host_sup_ok | output | 1 | Host supplies good, for power switching |

## Verification
The assertions assume that the supply flags and `vsel` are synchronous to `clk`, and that `host_rst_n` is the only asynchronous input. The bench therefore changes every input at the falling clock edge, so each change is seen cleanly at the next rising edge. Host reset pulses are given whole-cycle widths that fall clearly below or at the filter length. This keeps the accept-or-reject outcome free of synchronizer phase. Supply changes are spaced far enough apart that every timeout runs to completion before the next event.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef struct packed {
    logic host_ok;
    logic all_ok;
  } sup_stat_t;

  // vsel=1: 3.3 V only card, 5 V flags are not monitored
  function automatic sup_stat_t sup_eval(input logic vsel, input logic h5,
                                         input logic h3, input logic c5,
                                         input logic c3);
    sup_stat_t s;
    s.host_ok = h3 & (vsel | h5);
    s.all_ok  = s.host_ok & c3 & (vsel | c5);
    return s;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/srg_sync.sv
module srg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srg_glitch_filter.sv
module srg_glitch_filter #(
  parameter int unsigned GLITCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_in,
  output logic low_ok
);
  localparam int unsigned GW = srg_pkg::cnt_width(GLITCH_CYC);

  logic [GW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             low_cnt <= '0;
    else if (!low_in)                       low_cnt <= '0;
    else if (low_cnt != GW'(GLITCH_CYC))    low_cnt <= low_cnt + 1'b1;
  end

  assign low_ok = (low_cnt == GW'(GLITCH_CYC));

  // R6: an accepted low requires the input low in the cycle before
  a_r6_accept_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    low_ok |-> $past(low_in));
endmodule

// File: rtl/srg_reset_timer.sv
module srg_reset_timer #(
  parameter int unsigned TIMEOUT_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_ok,
  input  logic host_low,
  output logic rst_active,
  output logic host_start
);
  localparam int unsigned CW = srg_pkg::cnt_width(TIMEOUT_CYC);

  logic [CW-1:0] cnt;
  logic          host_low_q;
  logic          expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_low_q <= 1'b0;
    else        host_low_q <= host_low;
  end

  assign host_start = host_low & ~host_low_q;
  assign expired    = (cnt == CW'(TIMEOUT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_active <= 1'b1;
      cnt        <= '0;
    end else if (!sup_ok || host_start) begin
      rst_active <= 1'b1;
      cnt        <= '0;
    end else if (rst_active) begin
      if (!expired)       cnt        <= cnt + 1'b1;
      else if (!host_low) rst_active <= 1'b0;
    end
  end

  // R2: a supply fault forces the reset on the next edge
  a_r2_fault_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> rst_active);
  // R5: no release while the filtered host reset is low
  a_r5_no_release_host_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_active) |-> !$past(host_low));
  // R4: release only with good supplies
  a_r4_release_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_active) |-> $past(sup_ok));
  // R5: an accepted host reset asserts the reset
  a_r5_host_start_resets: assert property (@(posedge clk) disable iff (!rst_n)
    host_start |=> rst_active);
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
  parameter int unsigned TIMEOUT_CYC = 100,
  parameter int unsigned GLITCH_CYC  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host5_ok,
  input  logic host3_ok,
  input  logic card5_ok,
  input  logic card3_ok,
  input  logic vsel,
  input  logic host_rst_n,
  output logic card_rst_n,
  output logic card_rst,
  output logic card_v_good,
  output logic sig_valid_n,
  output logic host_sup_ok
);
  srg_pkg::sup_stat_t stat;
  logic host_rst_s;
  logic host_low;
  logic rst_active;
  logic host_start;
  logic cv_q;
  logic sv_q;

  assign stat = srg_pkg::sup_eval(vsel, host5_ok, host3_ok, card5_ok, card3_ok);

  srg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(host_rst_n), .q(host_rst_s));

  srg_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .low_in(~host_rst_s), .low_ok(host_low));

  srg_reset_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .sup_ok(stat.all_ok), .host_low(host_low),
    .rst_active(rst_active), .host_start(host_start));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q <= 1'b0;
      sv_q <= 1'b0;
    end else begin
      cv_q <= stat.all_ok;
      sv_q <= ~rst_active;
    end
  end

  assign card_rst_n  = ~rst_active;
  assign card_rst    = rst_active;
  assign card_v_good = cv_q;
  assign sig_valid_n = ~(sv_q & ~rst_active);
  assign host_sup_ok = stat.host_ok;

  // R7: signals valid only after a cycle of released reset
  a_r7_sv_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_valid_n |-> (card_rst_n && $past(card_rst_n)));
  // R2: card-voltage-good drops after a fault
  a_r2_cv_follows_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !stat.all_ok |=> !card_v_good);
  // R8: host reset start leaves card-voltage-good unchanged
  a_r8_host_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (host_start && stat.all_ok && $past(stat.all_ok)) |=> card_v_good);
endmodule

// File: tb/tb_supply_reset_gen.sv
module tb_supply_reset_gen;
  localparam int TO = 100;
  localparam int GL = 4;

  logic clk = 1'b0;
  logic rst_n, h5, h3, c5, c3, vsel, hrst_n;
  logic card_rst_n, card_rst, card_v_good, sig_valid_n, host_sup_ok;
  int checks = 0;
  int errors = 0;
  int mon_sv = 0;
  int mon_cmp = 0;
  bit done = 0;

  always #10 clk = ~clk;

  supply_reset_gen #(.TIMEOUT_CYC(TO), .GLITCH_CYC(GL)) dut (
    .clk(clk), .rst_n(rst_n), .host5_ok(h5), .host3_ok(h3), .card5_ok(c5),
    .card3_ok(c3), .vsel(vsel), .host_rst_n(hrst_n), .card_rst_n(card_rst_n),
    .card_rst(card_rst), .card_v_good(card_v_good), .sig_valid_n(sig_valid_n),
    .host_sup_ok(host_sup_ok));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R7 / R9 continuous monitors
  always @(negedge clk) if (rst_n === 1'b1) begin
    if (!card_rst_n && !sig_valid_n) mon_sv++;
    if (card_rst !== ~card_rst_n) mon_cmp++;
  end

  task automatic t_reset();
    cyc(3);
    chk("R1 card_rst_n", card_rst_n, 0);
    chk("R1 card_rst", card_rst, 1);
    chk("R1 card_v_good", card_v_good, 0);
    chk("R1 sig_valid_n", sig_valid_n, 1);
  endtask

  task automatic t_powerup();
    rst_n = 1'b1;
    cyc(10);
    chk("R2 held in reset while supplies bad", card_rst_n, 0);
    h5 = 1; h3 = 1; c5 = 1; c3 = 1;
    cyc(2);
    chk("R4 card_v_good after supplies good", card_v_good, 1);
    cyc(96);
    chk("R4 still in reset before timeout", card_rst_n, 0);
    cyc(6);
    chk("R4 released after timeout", card_rst_n, 1);
    cyc(2);
    chk("R7 sig_valid_n asserted after release", sig_valid_n, 0);
  endtask

  task automatic t_vsel_mask();
    vsel = 1; c5 = 0; h5 = 0;
    cyc(5);
    chk("R3 vsel=1 ignores 5V flags reset", card_rst_n, 1);
    chk("R3 vsel=1 ignores 5V flags cv", card_v_good, 1);
    chk("R8 host_sup_ok vsel=1", host_sup_ok, 1);
    vsel = 0;
    cyc(1);
    chk("R8 host_sup_ok vsel=0 host5 bad", host_sup_ok, 0);
    h5 = 1; c5 = 1; c3 = 0;
    cyc(2);
    chk("R2 card3 drop resets", card_rst_n, 0);
    chk("R2 card3 drop cv low", card_v_good, 0);
    chk("R7 sig_valid_n high on fault", sig_valid_n, 1);
    c3 = 1;
    cyc(TO + 6);
    chk("R4 recovered after card3 restore", card_rst_n, 1);
  endtask

  task automatic t_glitch();
    int hits = 0;
    hrst_n = 0; cyc(GL - 1); hrst_n = 1;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (!card_rst_n || sig_valid_n) hits++;
    end
    chk("R6 short host pulse ignored", hits, 0);
    hrst_n = 0; cyc(1); hrst_n = 1;
    cyc(10);
    chk("R6 one-cycle host pulse ignored", card_rst_n, 1);
  endtask

  task automatic t_host_short();
    hrst_n = 0; cyc(10); hrst_n = 1;
    cyc(10);
    chk("R5 short host reset active", card_rst_n, 0);
    chk("R8 host_sup_ok unaffected", host_sup_ok, 1);
    chk("R8 card_v_good unaffected", card_v_good, 1);
    cyc(80);
    chk("R5 timeout outlasts host low", card_rst_n, 0);
    cyc(25);
    chk("R5 released after timeout", card_rst_n, 1);
  endtask

  task automatic t_host_long();
    hrst_n = 0; cyc(299);
    chk("R5 long host reset active", card_rst_n, 0);
    chk("R8 host_sup_ok during long host reset", host_sup_ok, 1);
    cyc(1); hrst_n = 1;
    cyc(1);
    chk("R5 held just after host release", card_rst_n, 0);
    cyc(9);
    chk("R5 released after host high", card_rst_n, 1);
  endtask

  initial begin
    rst_n = 0; h5 = 0; h3 = 0; c5 = 0; c3 = 0; vsel = 0; hrst_n = 1;
    t_reset();
    t_powerup();
    t_vsel_mask();
    t_glitch();
    t_host_short();
    t_host_long();
    chk("R7 sig_valid_n never low during reset", mon_sv, 0);
    chk("R9 card_rst complements card_rst_n", mon_cmp, 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule